// File: doc/BRIEF.md
# Auto-Baud Key State Reporter

This block is the slave end of a polled serial link that reports ten key states to a host. The host sends one request character, 8N1 with the least significant bit first. The block times the first low run of that character to learn the host's bit period. It then reads the rest of the character at mid-bit and checks that it is the poll code. If it is, the block answers with two bytes at the same bit period.

The reply goes out on a shared, pulled-up half-duplex line. The block drives that line push-pull only while it sends, and lets go once the final stop bit has been driven. With the 2-wire select high, requests are taken from a separate receive-only pin and the reply still leaves on the shared line.

An active-low change flag tells the host when a poll is worth making. The flag falls when any key changes state. It is cleared as the reply starts, and it stays released while the reply is on the line.

Top module: `key_reporter`

## Requirements
- R1: After reset the line drive enable is low and the change flag is high, with all key inputs held at 0.
- R2: The bit period is the length of the request's first low run divided by 5, rounded to the nearest clock. The reply uses this same bit period at any rate whose five-bit low run fits in 2^CNT_W-1 clock cycles.
- R3: The reply is two 8N1 bytes sent least significant bit first.
  - The first byte holds keys 0 to 5 in bits 0 to 5.
  - The second byte holds keys 6 to 9 in bits 0 to 3, with bits 4 and 5 at 0.
  - In both bytes bit 6 is 1 and bit 7 is 0, so no active key gives 0x40, 0x40.
- R4: With keys 0, 2 and 7 active, the reply bytes are 0x45 then 0x42.
- R5: Timing of the reply on the line:
  - The reply's start bit begins between 1 and 3 bit periods after the end of the request's stop bit.
  - The drive enable stays high for exactly 20 bit periods and falls right after the second stop bit, which is driven high.
- R6: A change in any key input pulls the change flag low by the second clock edge after the change.
- R7: The change flag is high while the reply is driven. It stays high after the reply unless a key changed after the reply started, in which case it goes low when the drive enable falls.
- R8: A request whose byte is not 0x50, or whose stop bit samples low, gets no reply.
- R9: With the 2-wire select high, requests are taken only from the receive pin. A poll character on the shared line gets no reply.
- R10: A low run longer than 2^CNT_W-1 cycles is discarded and gets no reply. So is a measured bit period below 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| keys_i | input | 10 | Debounced key states, 1 = active |
| line_i | input | 1 | Level seen on the shared line |
| rx_i | input | 1 | Receive-only request pin |
| two_wire_i | input | 1 | 1 = take requests from rx_i |
| line_oe_o | output | 1 | Drive enable for the shared line |
| line_o | output | 1 | Data driven onto the shared line |
| chg_n_o | output | 1 | Change flag, active low |

## Verification
The bench builds the block with CNT_W = 10, so the measurement counter saturates at 1023 cycles. At that size a request at 250 cycles per bit overflows the measurement and is discarded. Requests at 40 to 173 cycles per bit fit and each get a full reply, so bit periods several times apart can be compared within one short run. A 3-cycle-per-bit request exercises the lower cut-off, and a key change made mid-reply shows whether the flag re-arms.

// File: rtl/kr_pkg.sv
package kr_pkg;
  localparam int unsigned NUM_KEYS   = 10;
  localparam int unsigned FRAME_BITS = 20;
  localparam int unsigned TAIL_BITS  = 5;
  localparam logic [7:0]  POLL_CODE  = 8'h50;
  // stop bit followed by data bits 7..4, in sampling order from MSB down
  localparam logic [TAIL_BITS-1:0] TAIL_CODE = {1'b1, POLL_CODE[7:4]};

  typedef enum logic [1:0] {RX_IDLE, RX_MEAS, RX_SAMP} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_GAP, TX_SEND} tx_state_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [NUM_KEYS-1:0] k);
    logic [7:0] lo_b, hi_b;
    lo_b = {2'b01, k[5:0]};
    hi_b = {4'b0100, k[9:6]};
    return {1'b1, hi_b, 1'b0, 1'b1, lo_b, 1'b0};
  endfunction
endpackage

// File: rtl/kr_sync.sv
module kr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/kr_autobaud_rx.sv
module kr_autobaud_rx
  import kr_pkg::*;
#(
  parameter int unsigned CNT_W   = 18,
  parameter int unsigned MIN_PER = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             line_i,
  output logic [CNT_W-1:0] per_o,
  output logic             ok_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] PER_MIN = CNT_W'(MIN_PER);
  localparam logic [CNT_W:0]   DIV     = (CNT_W+1)'(5);

  rx_state_e            state_q;
  logic [CNT_W-1:0]     cnt_q, tgt_q, per_q;
  logic [2:0]           bit_q;
  logic [TAIL_BITS-1:0] sh_q;
  logic                 prev_q;
  logic [CNT_W:0]       run_sum;
  logic [CNT_W-1:0]     per_calc;
  logic [TAIL_BITS-1:0] sh_nxt;

  assign run_sum  = {1'b0, cnt_q} + (CNT_W+1)'(2);
  assign per_calc = CNT_W'(run_sum / DIV);
  assign sh_nxt   = {line_i, sh_q[TAIL_BITS-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      tgt_q   <= '0;
      per_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      prev_q  <= 1'b1;
      ok_o    <= 1'b0;
    end else begin
      prev_q <= line_i;
      ok_o   <= 1'b0;
      if (hold_i) begin
        state_q <= RX_IDLE;
      end else begin
        unique case (state_q)
          RX_IDLE: if (prev_q && !line_i) begin
            state_q <= RX_MEAS;
            cnt_q   <= CNT_W'(1);
          end
          RX_MEAS: begin
            if (line_i) begin
              if (per_calc < PER_MIN) begin
                state_q <= RX_IDLE;
              end else begin
                state_q <= RX_SAMP;
                per_q   <= per_calc;
                tgt_q   <= per_calc >> 1;
                cnt_q   <= CNT_W'(1);
                bit_q   <= '0;
              end
            end else if (cnt_q == CNT_MAX) begin
              state_q <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          RX_SAMP: begin
            if (cnt_q == tgt_q) begin
              sh_q  <= sh_nxt;
              cnt_q <= CNT_W'(1);
              tgt_q <= per_q;
              bit_q <= bit_q + 3'd1;
              if (bit_q == 3'(TAIL_BITS-1)) begin
                state_q <= RX_IDLE;
                ok_o    <= (sh_nxt == TAIL_CODE);
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign per_o = per_q;
endmodule

// File: rtl/kr_reply_tx.sv
module kr_reply_tx
  import kr_pkg::*;
#(
  parameter int unsigned CNT_W = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                go_i,
  input  logic [CNT_W-1:0]    per_i,
  input  logic [NUM_KEYS-1:0] keys_i,
  output logic                busy_o,
  output logic                start_o,
  output logic                line_oe_o,
  output logic                line_o
);
  tx_state_e             state_q;
  logic [CNT_W-1:0]      cnt_q, per_q, gap_lim;
  logic [4:0]            bit_q;
  logic [FRAME_BITS-1:0] frame_q;

  assign gap_lim = per_q << 1;
  assign start_o = (state_q == TX_GAP) && (cnt_q == gap_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      per_q   <= '0;
      bit_q   <= '0;
      frame_q <= '1;
    end else begin
      unique case (state_q)
        TX_IDLE: if (go_i) begin
          state_q <= TX_GAP;
          per_q   <= per_i;
          cnt_q   <= CNT_W'(1);
        end
        TX_GAP: begin
          if (start_o) begin
            state_q <= TX_SEND;
            frame_q <= build_frame(keys_i);
            cnt_q   <= CNT_W'(1);
            bit_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        TX_SEND: begin
          if (cnt_q == per_q) begin
            cnt_q   <= CNT_W'(1);
            frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
            bit_q   <= bit_q + 5'd1;
            if (bit_q == 5'(FRAME_BITS-1)) state_q <= TX_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != TX_IDLE);
  assign line_oe_o = (state_q == TX_SEND);
  assign line_o    = (state_q == TX_SEND) ? frame_q[0] : 1'b1;
endmodule

// File: rtl/key_reporter.sv
module key_reporter
  import kr_pkg::*;
#(
  parameter int unsigned CNT_W       = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] keys_i,
  input  logic                line_i,
  input  logic                rx_i,
  input  logic                two_wire_i,
  output logic                line_oe_o,
  output logic                line_o,
  output logic                chg_n_o
);
  logic                req_raw, req_s, req_ok, tx_busy, tx_start;
  logic [CNT_W-1:0]    per;
  logic [NUM_KEYS-1:0] keys_q;
  logic                pend_q;

  assign req_raw = two_wire_i ? rx_i : line_i;

  kr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(req_raw), .q_o(req_s)
  );

  kr_autobaud_rx #(.CNT_W(CNT_W)) u_rx (
    .clk_i (clk_i), .rst_ni(rst_ni), .hold_i(tx_busy), .line_i(req_s),
    .per_o (per), .ok_o(req_ok)
  );

  kr_reply_tx #(.CNT_W(CNT_W)) u_tx (
    .clk_i    (clk_i),    .rst_ni (rst_ni),   .go_i     (req_ok),
    .per_i    (per),      .keys_i (keys_i),   .busy_o   (tx_busy),
    .start_o  (tx_start), .line_oe_o(line_oe_o), .line_o(line_o)
  );

  // a change on the start edge survives the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keys_q <= '0;
      pend_q <= 1'b0;
    end else begin
      keys_q <= keys_i;
      pend_q <= (keys_i != keys_q) | (pend_q & ~tx_start);
    end
  end

  assign chg_n_o = ~(pend_q & ~line_oe_o);
endmodule

// File: rtl/kr_checker.sv
module kr_checker
  import kr_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_KEYS-1:0] keys_i,
  input logic                line_oe_o,
  input logic                line_o,
  input logic                chg_n_o
);
  AST_FLAG_HIGH_IN_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_oe_o |-> chg_n_o); // R7

  AST_START_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_oe_o) |-> !line_o); // R3

  AST_STOP_BEFORE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_oe_o) |-> $past(line_o)); // R5

  AST_CHANGE_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keys_i != $past(keys_i)) |=> (!chg_n_o || line_oe_o)); // R6
endmodule

bind key_reporter kr_checker u_kr_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .keys_i   (keys_i),
  .line_oe_o(line_oe_o),
  .line_o   (line_o),
  .chg_n_o  (chg_n_o)
);

// File: tb/tb_key_reporter.sv
module tb_key_reporter;
  localparam int unsigned CW = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] keys = '0;
  logic       host_line = 1'b1, rx_pin = 1'b1, two_wire = 1'b0;
  logic       line_oe, line_d, chg_n;
  wire        line_bus = host_line & (line_oe ? line_d : 1'b1);

  always #2 clk = ~clk;

  key_reporter #(.CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .keys_i(keys), .line_i(line_bus),
    .rx_i(rx_pin), .two_wire_i(two_wire), .line_oe_o(line_oe),
    .line_o(line_d), .chg_n_o(chg_n)
  );

  typedef struct {logic [19:0] frame; int per; string tag;} exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0, replies = 0, last_end = 0;
  bit done = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [19:0] exp_frame(input logic [9:0] k);
    logic [7:0] b0, b1;
    b0 = 8'h40 | {2'b00, k[5:0]};
    b1 = 8'h40 | {4'b0000, k[9:6]};
    return {1'b1, b1, 1'b0, 1'b1, b0, 1'b0};
  endfunction

  task automatic send(input logic [7:0] code, input int per, input bit on_rx,
                      input bit stop_v, input bit expect_rep, input string tag);
    logic [9:0] bits;
    exp_t e;
    bits = {stop_v, code, 1'b0};
    if (expect_rep) begin
      e.frame = exp_frame(keys); e.per = per; e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      if (on_rx) rx_pin = bits[i]; else host_line = bits[i];
      repeat (per) @(negedge clk);
    end
    rx_pin = 1'b1; host_line = 1'b1;
    last_end = cyc;
  endtask

  // monitor: pops expectations and compares each reply
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && line_oe) begin
        replies++;
        if (q.size() == 0) begin
          chk(0, "R8", "unexpected reply", 1, 0);
          while (line_oe) @(negedge clk);
        end else begin
          exp_t e;
          logic [19:0] got;
          int d;
          e = q.pop_front();
          d = cyc - last_end;
          chk(d >= e.per && d <= 3 * e.per, "R5", "start delay", d, 2 * e.per);
          repeat (e.per / 2) @(negedge clk);
          for (int i = 0; i < 20; i++) begin
            got[i] = line_d;
            if (i == 0) chk(chg_n, "R7", "flag during reply", chg_n, 1);
            if (i < 19) repeat (e.per) @(negedge clk);
          end
          chk(got[8:1] == e.frame[8:1], e.tag, "first byte", got[8:1], e.frame[8:1]);
          chk(got[18:11] == e.frame[18:11], e.tag, "second byte", got[18:11], e.frame[18:11]);
          chk(got[0] == 0 && got[10] == 0 && got[9] && got[19], "R3", "framing", got, e.frame);
          repeat (e.per - e.per / 2 + 1) @(negedge clk);
          chk(!line_oe, "R5", "released after stop", line_oe, 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int r0;
    repeat (5) @(negedge clk);
    chk(!line_oe, "R1", "oe after reset", line_oe, 0);
    chk(chg_n, "R1", "flag after reset", chg_n, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!line_oe && chg_n, "R1", "idle after release", {line_oe, chg_n}, 1);

    // R3: no keys gives 0x40 0x40
    send(8'h50, 40, 0, 1, 1, "R3");
    repeat (26 * 40) @(negedge clk);

    // R6 then R4
    keys = 10'b00_1000_0101;
    repeat (2) @(negedge clk);
    chk(!chg_n, "R6", "flag after change", chg_n, 0);
    send(8'h50, 100, 0, 1, 1, "R4");
    repeat (26 * 100) @(negedge clk);
    chk(chg_n, "R7", "flag after reply", chg_n, 1);

    // R2: slow rate, all keys
    keys = '1;
    send(8'h50, 173, 0, 1, 1, "R2");
    repeat (26 * 173) @(negedge clk);

    // R9: two-wire mode
    two_wire = 1'b1;
    r0 = replies;
    send(8'h50, 60, 0, 1, 0, "R9");
    repeat (26 * 60) @(negedge clk);
    chk(replies == r0, "R9", "line ignored in 2-wire", replies - r0, 0);
    keys = 10'b10_0110_0011;
    send(8'h50, 60, 1, 1, 1, "R9");
    repeat (26 * 60) @(negedge clk);
    two_wire = 1'b0;

    // R8: wrong code and bad stop bit
    r0 = replies;
    send(8'h51, 50, 0, 1, 0, "R8");
    repeat (26 * 50) @(negedge clk);
    chk(replies == r0, "R8", "non-poll code", replies - r0, 0);
    send(8'h50, 50, 0, 0, 0, "R8");
    repeat (26 * 50) @(negedge clk);
    chk(replies == r0, "R8", "stop bit low", replies - r0, 0);

    // R10: overflowing low run and too short a period
    send(8'h50, 250, 0, 1, 0, "R10");
    repeat (26 * 250) @(negedge clk);
    chk(replies == r0, "R10", "overflow run", replies - r0, 0);
    send(8'h50, 3, 0, 1, 0, "R10");
    repeat (200) @(negedge clk);
    chk(replies == r0, "R10", "short period", replies - r0, 0);

    // R7: change during reply re-arms the flag after release
    keys = 10'b00_0000_0001;
    send(8'h50, 40, 0, 1, 1, "R3");
    while (!line_oe) @(negedge clk);
    repeat (40) @(negedge clk);
    keys = 10'b00_0000_0011;
    repeat (3) @(negedge clk);
    chk(chg_n, "R7", "flag held during reply", chg_n, 1);
    while (line_oe) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(!chg_n, "R7", "flag re-armed", chg_n, 0);
    repeat (100) @(negedge clk);
    chk(q.size() == 0, "R5", "all replies seen", q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule